// File: doc/BRIEF.md
# Serial port register core

This block is a byte-wide asynchronous serial port with eight register offsets on a simple synchronous bus. Host logic writes bytes into a one-byte transmit holding register. The transmitter then sends each byte on the serial output as a frame of 8 data bits, no parity bit and one stop bit. Bytes that arrive on the serial input land in a one-byte receive register. A single interrupt line reports that received data is waiting or that the transmit holding register has room. The interrupt is masked by an enable register and gated by a modem-control bit.

The bit rate comes from a 16-bit divisor. A 16x oversampling tick fires once every `divisor` clocks, so one serial bit lasts 16 x divisor clock cycles. A divisor of zero stops the tick. Offsets 0 and 1 are banked by bit 7 of the line-control register (offset 3). With that bit clear they reach the data and interrupt-enable registers. With it set they reach the low and high divisor bytes.

The transmitter state machine has four states: TX_IDLE, TX_START, TX_DATA and TX_STOP. It moves from TX_IDLE to TX_START on a tick while the holding register is full, and at that point takes the byte. It leaves TX_START after 16 ticks, leaves TX_DATA after the 8th bit, and returns from TX_STOP to TX_IDLE after 16 ticks. The receiver state machine has the states RX_IDLE, RX_START, RX_DATA and RX_STOP. It moves from RX_IDLE to RX_START on a tick that sees the input low. At the 8th tick it goes to RX_DATA if the input is still low, or back to RX_IDLE if the input is high. It moves to RX_STOP after the 8th data sample. It returns to RX_IDLE at the stop sample, and stores the byte only if the stop level is high.

Top module: `uart_regcore`

## Requirements
- R1: After reset the following hold: status (offset 5) reads 0x20; identification (offset 2) reads 0x01; irq_o is low; txd_o is high; the enable, line-control, modem-control and divisor registers all read 0.
- R2: When line-control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. When it is 0, offset 0 is the data register and offset 1 is the enable register. The enable register uses bit 0 for received data and bit 1 for transmit empty, and its other bits read 0. Offsets 2 to 5 ignore bit 7.
- R3: A byte written to offset 0 goes out LSB first as one low start bit, 8 data bits and one high stop bit. Each bit lasts 16 x divisor clocks. Status bit 5 is 0 while the holding register is occupied.
- R4: The receiver confirms a low start level at the 8th oversampling tick, then samples each data bit at mid-bit, LSB first. A frame with a high stop level stores the byte and sets status bit 0. A read of offset 0 with bank bit 0 clears status bit 0.
- R5: A frame whose stop level is low is discarded: status bit 0 stays 0, and the next good frame is received correctly.
- R6: The identification register reads 0x04 when status bit 0 and enable bit 0 are both set. Otherwise it reads 0x02 when the transmit-empty condition is pending and enable bit 1 is set. Otherwise it reads 0x01.
- R7: The transmit-empty condition becomes pending when the holding register goes from full to empty, or when enable bit 1 changes from 0 to 1 while the holding register is empty. It is cleared by a read of offset 2 that returns 0x02, or by a write to the data register.
- R8: irq_o equals modem-control bit 3 AND (identification value is not 0x01).
- R9: Writes to offset 2 change no register and no output.
- R10: With a divisor of 0 the transmitter does not leave TX_IDLE: a written byte stays held, status bit 5 stays 0 and txd_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; rdata_o updates at the same edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| txd_o | output | 1 | Serial output, idle high |
| rxd_i | input | 1 | Serial input |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases:
- Banking: a design that ignores bit 7 would return the divisor where the enable register should read back.
- Priority between pending conditions: a design with the wrong order would report 0x02 while received data waits.
- Clear-on-read: reading 0x04 must not clear the transmit-empty condition. A design that clears whatever it reports would lose that condition.
- Re-arming: the transmit-empty condition must come back when enable bit 1 is set again, and a data write must cancel it. A wrong design would leave the line asserted, or never raise it.
- Bad stop bit: a design that keeps a frame with a low stop level would show a false byte.
- Zero divisor: a design that does not halt would start the held frame.

// File: rtl/uart_regcore_pkg.sv
package uart_regcore_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_ENABLE = 3'd1;
    localparam logic [2:0] OFS_IDENT  = 3'd2;
    localparam logic [2:0] OFS_LINE   = 3'd3;
    localparam logic [2:0] OFS_MODEM  = 3'd4;
    localparam logic [2:0] OFS_STATUS = 3'd5;

    localparam logic [7:0] ID_NONE    = 8'h01;
    localparam logic [7:0] ID_TXEMPTY = 8'h02;
    localparam logic [7:0] ID_RXDATA  = 8'h04;

    localparam int BANK_BIT  = 7;
    localparam int GATE_BIT  = 3;
    localparam int EN_RX     = 0;
    localparam int EN_TX     = 1;
    localparam int RDY_BIT   = 0;
    localparam int EMPTY_BIT = 5;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_i == '0) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= div_i - 1'b1) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_regcore_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              empty_o,
    output logic              txd_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              full_q;
    logic [CW-1:0]     ocnt_q;
    logic [BW-1:0]     bcnt_q;
    logic              last_tick;

    assign last_tick = tick_i && (ocnt_q == CW'(OVS - 1));
    assign empty_o   = !full_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= TX_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (tick_i && full_q) state_d = TX_START;
            TX_START: if (last_tick) state_d = TX_DATA;
            TX_DATA:  if (last_tick && bcnt_q == BW'(DATA_W - 1)) state_d = TX_STOP;
            TX_STOP:  if (last_tick) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_q  <= '0;
            shift_q <= '0;
            full_q  <= 1'b0;
            ocnt_q  <= '0;
            bcnt_q  <= '0;
        end else begin
            if (state_q == TX_IDLE) begin
                ocnt_q <= '0;
                bcnt_q <= '0;
                if (state_d == TX_START) begin
                    shift_q <= hold_q;
                    full_q  <= 1'b0;
                end
            end else if (tick_i) begin
                ocnt_q <= last_tick ? '0 : ocnt_q + 1'b1;
                if (state_q == TX_DATA && last_tick) begin
                    shift_q <= shift_q >> 1;
                    bcnt_q  <= bcnt_q + 1'b1;
                end
            end
            if (load_i) begin
                hold_q <= din_i;
                full_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE:  txd_o = 1'b1;
            TX_START: txd_o = 1'b0;
            TX_DATA:  txd_o = shift_q[0];
            TX_STOP:  txd_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_regcore_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    rx_state_e         state_q, state_d;
    logic              sync1_q, sync2_q;
    logic [DATA_W-1:0] shift_q;
    logic [CW-1:0]     ocnt_q;
    logic [BW-1:0]     bcnt_q;
    logic              mid_tick, last_tick;

    assign mid_tick  = tick_i && (ocnt_q == CW'(OVS / 2 - 1));
    assign last_tick = tick_i && (ocnt_q == CW'(OVS - 1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RX_IDLE;
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            state_q <= state_d;
            sync1_q <= rxd_i;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick_i && !sync2_q) state_d = RX_START;
            RX_START: if (mid_tick) state_d = sync2_q ? RX_IDLE : RX_DATA;
            RX_DATA:  if (last_tick && bcnt_q == BW'(DATA_W - 1)) state_d = RX_STOP;
            RX_STOP:  if (last_tick) state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shift_q <= '0;
            ocnt_q  <= '0;
            bcnt_q  <= '0;
            data_o  <= '0;
            ready_o <= 1'b0;
        end else begin
            if (clr_i) ready_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    ocnt_q <= '0;
                    bcnt_q <= '0;
                end
                RX_START: if (tick_i) ocnt_q <= mid_tick ? '0 : ocnt_q + 1'b1;
                RX_DATA: if (tick_i) begin
                    ocnt_q <= last_tick ? '0 : ocnt_q + 1'b1;
                    if (last_tick) begin
                        shift_q <= {sync2_q, shift_q[DATA_W-1:1]};
                        bcnt_q  <= bcnt_q + 1'b1;
                    end
                end
                RX_STOP: if (tick_i) begin
                    ocnt_q <= last_tick ? '0 : ocnt_q + 1'b1;
                    if (last_tick && sync2_q) begin
                        data_o  <= shift_q;
                        ready_o <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_regcore.sv
module uart_regcore
    import uart_regcore_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              txd_o,
    input  logic              rxd_i,
    output logic              irq_o
);
    localparam int DIV_W = 2 * DATA_W;

    logic [DIV_W-1:0]  div_q;
    logic [1:0]        en_q;
    logic [DATA_W-1:0] line_q;
    logic              gate_q;
    logic              tx_pend;
    logic              empty_q;
    logic              bank;
    logic              tick;
    logic              thr_empty;
    logic              rx_ready;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] ident;
    logic [DATA_W-1:0] rd_val;
    logic              data_wr, data_rd, pend_set, pend_clr;

    assign bank    = line_q[BANK_BIT];
    assign data_wr = wr_i && addr_i == OFS_DATA && !bank;
    assign data_rd = rd_i && addr_i == OFS_DATA && !bank;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (div_q),
        .tick_o (tick)
    );

    uart_tx_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .load_i  (data_wr),
        .din_i   (wdata_i),
        .empty_o (thr_empty),
        .txd_o   (txd_o)
    );

    uart_rx_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .rxd_i   (rxd_i),
        .clr_i   (data_rd),
        .data_o  (rx_data),
        .ready_o (rx_ready)
    );

    always_comb begin
        if (rx_ready && en_q[EN_RX])      ident = ID_RXDATA;
        else if (tx_pend && en_q[EN_TX])  ident = ID_TXEMPTY;
        else                              ident = ID_NONE;
    end

    assign irq_o = gate_q && (ident != ID_NONE);

    assign pend_set = (thr_empty && !empty_q) ||
                      (wr_i && addr_i == OFS_ENABLE && !bank &&
                       wdata_i[EN_TX] && !en_q[EN_TX] && thr_empty);
    assign pend_clr = data_wr || (rd_i && addr_i == OFS_IDENT && ident == ID_TXEMPTY);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q   <= '0;
            en_q    <= '0;
            line_q  <= '0;
            gate_q  <= 1'b0;
            tx_pend <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            empty_q <= thr_empty;
            if (pend_set)      tx_pend <= 1'b1;
            else if (pend_clr) tx_pend <= 1'b0;
            if (wr_i) begin
                unique case (addr_i)
                    OFS_DATA:   if (bank) div_q[DATA_W-1:0] <= wdata_i;
                    OFS_ENABLE: begin
                        if (bank) div_q[DIV_W-1:DATA_W] <= wdata_i;
                        else      en_q <= wdata_i[1:0];
                    end
                    OFS_LINE:   line_q <= wdata_i;
                    OFS_MODEM:  gate_q <= wdata_i[GATE_BIT];
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (addr_i)
            OFS_DATA:   rd_val = bank ? div_q[DATA_W-1:0] : rx_data;
            OFS_ENABLE: rd_val = bank ? div_q[DIV_W-1:DATA_W] : {{(DATA_W-2){1'b0}}, en_q};
            OFS_IDENT:  rd_val = ident;
            OFS_LINE:   rd_val = line_q;
            OFS_MODEM:  rd_val[GATE_BIT] = gate_q;
            OFS_STATUS: begin
                rd_val[EMPTY_BIT] = thr_empty;
                rd_val[RDY_BIT]   = rx_ready;
            end
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)   rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_val;
    end
endmodule

// File: rtl/uart_regcore_chk.sv
module uart_regcore_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        irq_o,
    input logic        gate_q,
    input logic        txd_o,
    input logic [15:0] div_q,
    input logic        tx_pend,
    input logic        wr_i,
    input logic        rd_i,
    input logic [2:0]  addr_i,
    input logic        bank,
    input logic        rx_ready,
    input logic [7:0]  ident
);
    assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> gate_q);

    assert_ident_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ident == 8'h01) || (ident == 8'h02) || (ident == 8'h04));

    assert_div_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_q == 16'h0 && $past(div_q) == 16'h0) |=> $stable(txd_o));

    assert_rx_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == 3'd0 && !bank) |=> !rx_ready);

    assert_thr_write_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd0 && !bank) |=> !tx_pend);
endmodule

bind uart_regcore uart_regcore_chk u_chk (.*);

// File: tb/sim_uart_regcore.sv
`timescale 1ns/1ps
module sim_uart_regcore;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd, irq;
    logic       rxd = 1'b1;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    uart_regcore u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rxd), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] e);
        logic [7:0] v;
        rreg(a, v);
        chk(tag, v, e);
    endtask

    // 16 clocks per bit with divisor 1
    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16) @(negedge clk);
        end
        rxd = stop;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic capture(input string tag, input logic [7:0] exp);
        logic [7:0] b;
        logic       s0, s1;
        for (int i = 0; i < 4000 && txd; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        s0 = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            b[i] = txd;
        end
        repeat (16) @(negedge clk);
        s1 = txd;
        chk({tag, " start"}, {7'b0, s0}, 8'h00);
        chk({tag, " data"}, b, exp);
        chk({tag, " stop"}, {7'b0, s1}, 8'h01);
    endtask

    task automatic t_reset;  // R1
        @(negedge clk);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 txd", {7'b0, txd}, 8'h01);
        expect_reg("R1 status", 3'd5, 8'h20);
        expect_reg("R1 ident", 3'd2, 8'h01);
        expect_reg("R1 enable", 3'd1, 8'h00);
        expect_reg("R1 line", 3'd3, 8'h00);
        expect_reg("R1 modem", 3'd4, 8'h00);
        wreg(3'd3, 8'h80);
        expect_reg("R1 div lo", 3'd0, 8'h00);
        expect_reg("R1 div hi", 3'd1, 8'h00);
        wreg(3'd3, 8'h03);
    endtask

    task automatic t_halt_then_tx;  // R10, R3
        wreg(3'd0, 8'h55);
        repeat (300) @(negedge clk);
        chk("R10 txd held", {7'b0, txd}, 8'h01);
        expect_reg("R10 status", 3'd5, 8'h00);
        wreg(3'd3, 8'h83);
        wreg(3'd1, 8'h00);
        wreg(3'd0, 8'h01);
        capture("R3 frame55", 8'h55);
        wreg(3'd3, 8'h03);
        expect_reg("R3 status empty", 3'd5, 8'h20);
        wreg(3'd0, 8'hC3);
        capture("R3 frameC3", 8'hC3);
    endtask

    task automatic t_bank;  // R2
        wreg(3'd3, 8'h80);
        wreg(3'd0, 8'h34);
        wreg(3'd1, 8'h12);
        expect_reg("R2 div lo", 3'd0, 8'h34);
        expect_reg("R2 div hi", 3'd1, 8'h12);
        expect_reg("R2 line", 3'd3, 8'h80);
        expect_reg("R2 status banked", 3'd5, 8'h20);
        wreg(3'd3, 8'h00);
        expect_reg("R2 enable", 3'd1, 8'h00);
        wreg(3'd1, 8'hFF);
        expect_reg("R2 enable mask", 3'd1, 8'h03);
        wreg(3'd1, 8'h00);
        wreg(3'd3, 8'h80);
        expect_reg("R2 div kept", 3'd0, 8'h34);
        wreg(3'd0, 8'h01);
        wreg(3'd1, 8'h00);
        wreg(3'd3, 8'h03);
    endtask

    task automatic t_rx;  // R4
        send_frame(8'hA5, 1'b1);
        expect_reg("R4 ready", 3'd5, 8'h21);
        expect_reg("R4 data", 3'd0, 8'hA5);
        expect_reg("R4 cleared", 3'd5, 8'h20);
        send_frame(8'h3C, 1'b1);
        expect_reg("R4 data2", 3'd0, 8'h3C);
    endtask

    task automatic t_badstop;  // R5
        send_frame(8'h5A, 1'b0);
        repeat (32) @(negedge clk);
        expect_reg("R5 discarded", 3'd5, 8'h20);
        send_frame(8'h81, 1'b1);
        expect_reg("R5 recover ready", 3'd5, 8'h21);
        expect_reg("R5 recover data", 3'd0, 8'h81);
    endtask

    task automatic t_ident;  // R6, R7
        wreg(3'd1, 8'h00);
        wreg(3'd1, 8'h02);
        expect_reg("R7 enable arms", 3'd2, 8'h02);
        expect_reg("R7 read clears", 3'd2, 8'h01);
        wreg(3'd1, 8'h00);
        wreg(3'd1, 8'h03);
        send_frame(8'h77, 1'b1);
        expect_reg("R6 rx first", 3'd2, 8'h04);
        expect_reg("R6 rx again", 3'd2, 8'h04);
        expect_reg("R6 data", 3'd0, 8'h77);
        expect_reg("R6 tx next", 3'd2, 8'h02);
        expect_reg("R6 none", 3'd2, 8'h01);
    endtask

    task automatic t_gate;  // R8
        send_frame(8'h11, 1'b1);
        wreg(3'd4, 8'h00);
        chk("R8 gated off", {7'b0, irq}, 8'h00);
        wreg(3'd4, 8'h08);
        chk("R8 gated on", {7'b0, irq}, 8'h01);
        expect_reg("R8 data", 3'd0, 8'h11);
        chk("R8 drops", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_thr_clear;  // R7, R10
        wreg(3'd1, 8'h00);
        wreg(3'd1, 8'h02);
        chk("R7 armed irq", {7'b0, irq}, 8'h01);
        wreg(3'd3, 8'h80);
        wreg(3'd0, 8'h00);
        wreg(3'd3, 8'h00);
        wreg(3'd0, 8'h99);
        chk("R7 write clears irq", {7'b0, irq}, 8'h00);
        repeat (100) @(negedge clk);
        chk("R10 still held", {7'b0, txd}, 8'h01);
        chk("R7 stays clear", {7'b0, irq}, 8'h00);
        wreg(3'd3, 8'h80);
        wreg(3'd1, 8'h00);
        wreg(3'd0, 8'h01);
        capture("R3 frame99", 8'h99);
        wreg(3'd3, 8'h00);
        chk("R7 empty edge irq", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_fifo;  // R9
        wreg(3'd2, 8'hC7);
        chk("R9 irq", {7'b0, irq}, 8'h01);
        chk("R9 txd", {7'b0, txd}, 8'h01);
        expect_reg("R9 status", 3'd5, 8'h20);
        expect_reg("R9 line", 3'd3, 8'h00);
        expect_reg("R9 enable", 3'd1, 8'h02);
        expect_reg("R9 ident", 3'd2, 8'h02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halt_then_tx();
        t_bank();
        t_rx();
        t_badstop();
        t_ident();
        t_gate();
        t_thr_clear();
        t_fifo();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule